// File: doc/BRIEF.md
# 16-bit ALU with Status and Control Flag Register

This block is the arithmetic and logic core of a small 16-bit execution unit. It takes two 16-bit operands and a 3-bit operation code. It produces a combinational result. It also keeps a registered flag word. That word holds six status flags, which track the outcome of the last flag-updating operation, and three control flags, which only explicit set and clear strobes can change.

Each operation runs either on the full 16-bit word or on the low byte alone. In byte mode the result is 8 bits wide, and every width-dependent flag comes from that 8-bit result. The add-with-carry and subtract-with-borrow operations use the registered carry flag as their carry-in. This lets multi-word arithmetic be chained across cycles.

Status flags change only on a rising clock edge while the update enable is high. The result output is always live. A caller can therefore compute a value without disturbing the flags.

Top module: `ex_alu`

## Requirements
- R1: Operation codes are 0 = add, 1 = add-with-carry, 2 = subtract, 3 = subtract-with-borrow, 4 = AND, 5 = OR, 6 = XOR, 7 = pass `opb`. Add gives `opa + opb`, plus the registered carry flag for code 1. After a flag update, `cf_o` holds the carry out of the top result bit.
- R2: Subtract gives `opa - opb`, minus the registered carry flag for code 3. After a flag update, `cf_o` is 1 exactly when a borrow out of the top bit occurred.
- R3: After an arithmetic flag update, `of_o` is 1 exactly when the true signed (two's complement) result does not fit the result width.
- R4: After an arithmetic flag update, `af_o` is the carry (for add) or borrow (for subtract) from bit 3 into bit 4. Codes 4 to 7 leave `af_o` unchanged.
- R5: After a flag update, `zf_o` is 1 when the result of the active width is zero. `sf_o` equals the top bit of the active width (bit 15 for word, bit 7 for byte).
- R6: After a flag update, `pf_o` is 1 when bits 7:0 of the result hold an even number of ones.
- R7: Codes 4 to 7 give the bitwise result (or `opb` for code 7). A flag update with any of these codes clears `cf_o` and `of_o`.
- R8: With `byte_mode` = 1, bits 7:0 of `result` are the 8-bit result of the operation on bits 7:0 of the operands. Bits 15:8 of `result` are 0. Carry, overflow, sign and zero use the 8-bit result.
- R9: The six status flags change only at a rising clock edge with `flag_we` = 1. Otherwise they hold, while `result` still follows the inputs combinationally.
- R10: `set_df`/`clr_df`, `set_if`/`clr_if` and `set_tf`/`clr_tf` set or clear the direction, interrupt-enable and trap flags at the next edge. Set wins when both strobes are high. These strobes act regardless of `flag_we`, and status updates never change the control flags.
- R11: A synchronous active-low reset clears all nine flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| op | input | 3 | Operation code (see R1) |
| byte_mode | input | 1 | 1 = operate on bits 7:0 only |
| flag_we | input | 1 | Update status flags at the next edge |
| set_df | input | 1 | Set direction flag |
| clr_df | input | 1 | Clear direction flag |
| set_if | input | 1 | Set interrupt-enable flag |
| clr_if | input | 1 | Clear interrupt-enable flag |
| set_tf | input | 1 | Set trap flag |
| clr_tf | input | 1 | Clear trap flag |
| result | output | 16 | Combinational result |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even-parity flag of result bits 7:0 |
| af_o | output | 1 | Nibble carry / borrow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |
| df_o | output | 1 | Direction control flag |
| if_o | output | 1 | Interrupt-enable control flag |
| tf_o | output | 1 | Trap control flag |

## Verification
The only internal state is the flag word. A wrong flag shows up on its output pin one edge after the update that wrote it. A wrong carry also corrupts the `result` of the very next add-with-carry or subtract-with-borrow, so an ADC or SBB follows each carry-producing step. A flag that should have held but was disturbed, by a disabled update or by a logic operation touching the nibble carry, is visible on the flag pins at the edge it was wrongly written. Byte mode is exercised with operands whose high bytes would change the flags if they leaked into the 8-bit computation.

// File: rtl/ex_alu_pkg.sv
// Package: shared types for the ALU and its flag register.
// Assumes a 3-bit operation code; the status word is packed in a fixed order.
package ex_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

    // True for the operations that feed the adder/subtracter.
    function automatic logic op_is_arith(alu_op_e o);
        return (o == OP_ADD) || (o == OP_ADC) || (o == OP_SUB) || (o == OP_SBB);
    endfunction

    // True for the operations that use the stored carry as carry-in.
    function automatic logic op_uses_carry(alu_op_e o);
        return (o == OP_ADC) || (o == OP_SBB);
    endfunction

    // True for subtract flavours.
    function automatic logic op_is_sub(alu_op_e o);
        return (o == OP_SUB) || (o == OP_SBB);
    endfunction

endpackage

// File: rtl/ex_alu_lane.sv
// Module: ex_alu_lane
// One width-specific ALU slice. Computes the result plus the raw carry,
// nibble carry and signed overflow for a W-bit operation.
// Assumes W >= 5 so that a bit-3-to-bit-4 carry exists.
module ex_alu_lane
    import ex_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         aux,
    output logic         ovf
);

    localparam int NIB = 4;

    logic [W:0] ext;
    logic       sub;

    assign sub = op_is_sub(op);

    // Extended add or subtract including carry/borrow-in.
    always_comb begin
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
    end

    // Result select and raw arithmetic condition bits.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = b;
            default: res = ext[W-1:0];
        endcase
        cout = ext[W];
        aux  = a[NIB] ^ b[NIB] ^ ext[NIB];
        if (sub) begin
            ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
        end else begin
            ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
        end
    end

endmodule

// File: rtl/ex_alu_datapath.sv
// Module: ex_alu_datapath
// Runs a byte lane and a word lane side by side (generated) and selects
// the one chosen by byte_mode. The byte result is zero-extended.
// Assumes BYTE_W < DATA_W.
module ex_alu_datapath
    import ex_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic              carry_q,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              aux,
    output logic              ovf
);

    localparam int NLANE = 2;

    logic [DATA_W-1:0] lane_res [NLANE];
    logic              lane_co  [NLANE];
    logic              lane_ax  [NLANE];
    logic              lane_ov  [NLANE];
    logic              cin;

    assign cin = op_uses_carry(op) & carry_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        logic [LW-1:0] r;
        logic          co;
        logic          ax;
        logic          ov;

        ex_alu_lane #(.W(LW)) u_lane (
            .a    (opa[LW-1:0]),
            .b    (opb[LW-1:0]),
            .cin  (cin),
            .op   (op),
            .res  (r),
            .cout (co),
            .aux  (ax),
            .ovf  (ov)
        );

        assign lane_res[g] = DATA_W'(r);
        assign lane_co[g]  = co;
        assign lane_ax[g]  = ax;
        assign lane_ov[g]  = ov;
    end

    // Pick the lane that matches the requested width.
    always_comb begin
        if (byte_mode) begin
            res  = lane_res[0];
            cout = lane_co[0];
            aux  = lane_ax[0];
            ovf  = lane_ov[0];
        end else begin
            res  = lane_res[1];
            cout = lane_co[1];
            aux  = lane_ax[1];
            ovf  = lane_ov[1];
        end
    end

endmodule

// File: rtl/ex_alu_flaggen.sv
// Module: ex_alu_flaggen
// Forms the next status word from the selected result and raw condition
// bits. Logic operations clear carry/overflow and keep the nibble carry.
// Assumes res is already zero-extended in byte mode.
module ex_alu_flaggen
    import ex_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    input  logic              aux,
    input  logic              ovf,
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic              af_q,
    output status_t           st_d
);

    logic arith;

    assign arith = op_is_arith(op);

    // Next status word.
    always_comb begin
        st_d.cf = arith & cout;
        st_d.of = arith & ovf;
        st_d.af = arith ? aux : af_q;
        st_d.pf = ~^res[BYTE_W-1:0];
        st_d.zf = byte_mode ? (res[BYTE_W-1:0] == '0) : (res == '0);
        st_d.sf = byte_mode ? res[BYTE_W-1] : res[DATA_W-1];
    end

endmodule

// File: rtl/ex_alu_flagreg.sv
// Module: ex_alu_flagreg
// Holds the six status flags (written by update enable) and the three
// control flags (written only by set/clear strobes, set has priority).
// Synchronous active-low reset clears everything.
module ex_alu_flagreg
    import ex_alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    we,
    input  status_t st_d,
    input  logic    set_df,
    input  logic    clr_df,
    input  logic    set_if,
    input  logic    clr_if,
    input  logic    set_tf,
    input  logic    clr_tf,
    output status_t st_q,
    output logic    df_q,
    output logic    if_q,
    output logic    tf_q
);

    // Status flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (we) begin
            st_q <= st_d;
        end
    end

    // Control flag storage, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            df_q <= 1'b0;
            if_q <= 1'b0;
            tf_q <= 1'b0;
        end else begin
            if (set_df)      df_q <= 1'b1;
            else if (clr_df) df_q <= 1'b0;
            if (set_if)      if_q <= 1'b1;
            else if (clr_if) if_q <= 1'b0;
            if (set_tf)      tf_q <= 1'b1;
            else if (clr_tf) tf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ex_alu.sv
// Module: ex_alu (top)
// 16-bit ALU with byte/word width and a registered nine-flag word.
// Result is combinational; flags change only at clock edges.
module ex_alu
    import ex_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        op,
    input  logic              byte_mode,
    input  logic              flag_we,
    input  logic              set_df,
    input  logic              clr_df,
    input  logic              set_if,
    input  logic              clr_if,
    input  logic              set_tf,
    input  logic              clr_tf,
    output logic [DATA_W-1:0] result,
    output logic              cf_o,
    output logic              pf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o,
    output logic              df_o,
    output logic              if_o,
    output logic              tf_o
);

    alu_op_e     op_e;
    status_t     st_d;
    status_t     st_q;
    logic        cout;
    logic        aux;
    logic        ovf;

    assign op_e = alu_op_e'(op);

    ex_alu_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
        .opa       (opa),
        .opb       (opb),
        .op        (op_e),
        .byte_mode (byte_mode),
        .carry_q   (st_q.cf),
        .res       (result),
        .cout      (cout),
        .aux       (aux),
        .ovf       (ovf)
    );

    ex_alu_flaggen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fg (
        .res       (result),
        .cout      (cout),
        .aux       (aux),
        .ovf       (ovf),
        .op        (op_e),
        .byte_mode (byte_mode),
        .af_q      (st_q.af),
        .st_d      (st_d)
    );

    ex_alu_flagreg u_fr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (flag_we),
        .st_d   (st_d),
        .set_df (set_df),
        .clr_df (clr_df),
        .set_if (set_if),
        .clr_if (clr_if),
        .set_tf (set_tf),
        .clr_tf (clr_tf),
        .st_q   (st_q),
        .df_q   (df_o),
        .if_q   (if_o),
        .tf_q   (tf_o)
    );

    assign cf_o = st_q.cf;
    assign pf_o = st_q.pf;
    assign af_o = st_q.af;
    assign zf_o = st_q.zf;
    assign sf_o = st_q.sf;
    assign of_o = st_q.of;

endmodule

// File: rtl/ex_alu_chk.sv
// Module: ex_alu_chk
// Assertion checker bound to ex_alu; observes ports only.
module ex_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] result,
    input logic [2:0]  op,
    input logic        byte_mode,
    input logic        flag_we,
    input logic        set_df,
    input logic        clr_df,
    input logic        set_if,
    input logic        cf_o,
    input logic        pf_o,
    input logic        af_o,
    input logic        zf_o,
    input logic        sf_o,
    input logic        of_o,
    input logic        df_o,
    input logic        if_o
);

    // R7: logic update clears carry and overflow
    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op[2]) |=> (!cf_o && !of_o));

    // R4: logic update keeps the nibble carry
    p_af_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op[2]) |=> (af_o == $past(af_o)));

    // R9: no update enable, status flags hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> ($stable(cf_o) && $stable(pf_o) && $stable(af_o)
                      && $stable(zf_o) && $stable(sf_o) && $stable(of_o)));

    // R5: zero flag follows the result of the active width
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (zf_o == $past(byte_mode ? (result[7:0] == 8'h00) : (result == 16'h0000))));

    // R6: parity flag follows low-byte ones count
    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (pf_o == $past(($countones(result[7:0]) % 2) == 0)));

    // R8: high byte zero in byte mode
    p_byte_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (result[15:8] == 8'h00));

    // R10: set strobe wins
    p_set_df_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_df |=> df_o);

    // R10: lone clear strobe clears
    p_clr_df_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_df && !set_df) |=> !df_o);

    // R10: interrupt flag set strobe
    p_set_if_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_if |=> if_o);

endmodule

bind ex_alu ex_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .result    (result),
    .op        (op),
    .byte_mode (byte_mode),
    .flag_we   (flag_we),
    .set_df    (set_df),
    .clr_df    (clr_df),
    .set_if    (set_if),
    .cf_o      (cf_o),
    .pf_o      (pf_o),
    .af_o      (af_o),
    .zf_o      (zf_o),
    .sf_o      (sf_o),
    .of_o      (of_o),
    .df_o      (df_o),
    .if_o      (if_o)
);

// File: tb/sim_ex_alu.sv
`timescale 1ns/1ps
module sim_ex_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0;
    logic [2:0]  op = '0;
    logic        byte_mode = 1'b0, flag_we = 1'b0;
    logic        set_df = 1'b0, clr_df = 1'b0, set_if = 1'b0, clr_if = 1'b0;
    logic        set_tf = 1'b0, clr_tf = 1'b0;
    logic [15:0] result;
    logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o, df_o, if_o, tf_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench-side flag model {cf,pf,af,zf,sf,of} and control {df,if,tf}
    logic [5:0] m_st = '0;
    logic [2:0] m_ct = '0;

    always #2.5 clk = ~clk;

    ex_alu u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
        .byte_mode(byte_mode), .flag_we(flag_we),
        .set_df(set_df), .clr_df(clr_df), .set_if(set_if), .clr_if(clr_if),
        .set_tf(set_tf), .clr_tf(clr_tf), .result(result),
        .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o),
        .of_o(of_o), .df_o(df_o), .if_o(if_o), .tf_o(tf_o)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference computation from the requirement text, integer arithmetic.
    function automatic logic [21:0] model(logic [15:0] a, logic [15:0] b,
                                          logic [2:0] o, logic bm, logic [5:0] st);
        int mask, half, ua, ub, c, r, sa, sb, sr, ones;
        logic ncf, naf, nof, nzf, nsf, npf;
        mask = bm ? 255 : 65535;
        half = bm ? 128 : 32768;
        ua = int'(a) & mask;
        ub = int'(b) & mask;
        c  = (o == 3'd1 || o == 3'd3) ? int'(st[5]) : 0;
        sa = (ua >= half) ? ua - 2 * half : ua;
        sb = (ub >= half) ? ub - 2 * half : ub;
        ncf = 1'b0; nof = 1'b0; naf = st[3];
        r = 0;
        case (o)
            3'd0, 3'd1: begin
                r = ua + ub + c; ncf = (r > mask);
                naf = (((ua & 15) + (ub & 15) + c) > 15);
                sr = sa + sb + c; nof = (sr >= half) || (sr < -half);
            end
            3'd2, 3'd3: begin
                r = ua - ub - c; ncf = (r < 0);
                naf = (((ua & 15) - (ub & 15) - c) < 0);
                sr = sa - sb - c; nof = (sr >= half) || (sr < -half);
            end
            3'd4: r = ua & ub;
            3'd5: r = ua | ub;
            3'd6: r = ua ^ ub;
            default: r = ub;
        endcase
        r = r & mask;
        nzf = (r == 0);
        nsf = (r >= half);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        npf = (ones % 2 == 0);
        return {r[15:0], ncf, npf, naf, nzf, nsf, nof};
    endfunction

    // Apply one operation, check result combinationally and flags after edge.
    task automatic run_op(string tag, logic [15:0] a, logic [15:0] b,
                          logic [2:0] o, logic bm, logic we);
        logic [21:0] exp;
        @(negedge clk);
        opa = a; opb = b; op = o; byte_mode = bm; flag_we = we;
        exp = model(a, b, o, bm, m_st);
        #1;
        check(tag, "result", result, exp[21:6]);
        @(posedge clk);
        #1;
        if (we) m_st = exp[5:0];
        check(tag, "status{cf,pf,af,zf,sf,of}",
              {10'd0, cf_o, pf_o, af_o, zf_o, sf_o, of_o}, {10'd0, m_st});
        check(tag, "control{df,if,tf}", {13'd0, df_o, if_o, tf_o}, {13'd0, m_ct});
        flag_we = 1'b0;
    endtask

    // Pulse control strobes for one edge.
    task automatic ctrl_pulse(string tag, logic [5:0] s);
        @(negedge clk);
        {set_df, clr_df, set_if, clr_if, set_tf, clr_tf} = s;
        if (s[5]) m_ct[2] = 1'b1; else if (s[4]) m_ct[2] = 1'b0;
        if (s[3]) m_ct[1] = 1'b1; else if (s[2]) m_ct[1] = 1'b0;
        if (s[1]) m_ct[0] = 1'b1; else if (s[0]) m_ct[0] = 1'b0;
        @(posedge clk);
        #1;
        check(tag, "control{df,if,tf}", {13'd0, df_o, if_o, tf_o}, {13'd0, m_ct});
        check(tag, "status untouched", {10'd0, cf_o, pf_o, af_o, zf_o, sf_o, of_o}, {10'd0, m_st});
        {set_df, clr_df, set_if, clr_if, set_tf, clr_tf} = '0;
    endtask

    task automatic t_reset();
        // R11: all flags clear after reset
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_st = '0; m_ct = '0;
        check("R11", "all flags", {7'd0, cf_o, pf_o, af_o, zf_o, sf_o, of_o, df_o, if_o, tf_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add_word();
        run_op("R1", 16'hFFFF, 16'h0001, 3'd0, 1'b0, 1'b1);  // carry, zero, aux
        run_op("R1", 16'h1234, 16'h0001, 3'd1, 1'b0, 1'b1);  // ADC with cf=1 -> 1236
        run_op("R3", 16'h7FFF, 16'h0001, 3'd0, 1'b0, 1'b1);  // signed overflow, sign
        run_op("R5", 16'h8000, 16'h8000, 3'd0, 1'b0, 1'b1);  // zero with carry+ovf
        run_op("R6", 16'h0003, 16'h0004, 3'd0, 1'b0, 1'b1);  // 7: odd ones -> pf 0
    endtask

    task automatic t_sub_word();
        run_op("R2", 16'h0000, 16'h0001, 3'd2, 1'b0, 1'b1);  // borrow
        run_op("R2", 16'h0005, 16'h0002, 3'd3, 1'b0, 1'b1);  // SBB with borrow -> 2
        run_op("R3", 16'h8000, 16'h0001, 3'd2, 1'b0, 1'b1);  // signed overflow
        run_op("R4", 16'h0010, 16'h0001, 3'd2, 1'b0, 1'b1);  // nibble borrow
    endtask

    task automatic t_logic();
        run_op("R7", 16'hFFFF, 16'h0001, 3'd0, 1'b0, 1'b1);  // set cf, af
        run_op("R7", 16'hF0F0, 16'h3C3C, 3'd4, 1'b0, 1'b1);  // AND clears cf, keeps af
        run_op("R4", 16'h000F, 16'h0001, 3'd0, 1'b0, 1'b1);  // af=1
        run_op("R4", 16'h1200, 16'h0034, 3'd5, 1'b0, 1'b1);  // OR keeps af=1
        run_op("R7", 16'hAAAA, 16'hFFFF, 3'd6, 1'b0, 1'b1);  // XOR
        run_op("R7", 16'h1111, 16'h8000, 3'd7, 1'b0, 1'b1);  // pass, sign
    endtask

    task automatic t_byte();
        run_op("R8", 16'h12FF, 16'h3401, 3'd0, 1'b1, 1'b1);  // byte carry, zero
        run_op("R8", 16'hFF7F, 16'h0001, 3'd0, 1'b1, 1'b1);  // byte overflow, sign
        run_op("R8", 16'hAB00, 16'hCD01, 3'd2, 1'b1, 1'b1);  // byte borrow -> FF
        run_op("R8", 16'hFFFF, 16'hFF0F, 3'd4, 1'b1, 1'b1);  // byte AND, hi zero
    endtask

    task automatic t_hold();
        run_op("R9", 16'h0001, 16'h0001, 3'd0, 1'b0, 1'b1);  // known state
        run_op("R9", 16'hFFFF, 16'hFFFF, 3'd0, 1'b0, 1'b0);  // no update
        run_op("R9", 16'h8000, 16'h0001, 3'd2, 1'b0, 1'b0);  // no update
    endtask

    task automatic t_ctrl();
        ctrl_pulse("R10", 6'b100000);  // set df
        ctrl_pulse("R10", 6'b001100);  // set+clr if -> set wins
        ctrl_pulse("R10", 6'b000010);  // set tf
        run_op("R10", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b1);  // status write keeps control
        ctrl_pulse("R10", 6'b010101);  // clear all
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add_word();
        t_sub_word();
        t_logic();
        t_byte();
        t_hold();
        t_ctrl();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule